// File: doc/BRIEF.md
# Queued Word-DMA Engine with Loopback Write-Back

This block runs memory-to-memory transfer commands that software posts through a small register window. Four registers hold source address, destination address, source length and destination length. Writing the destination length is the trigger: the four values are snapshotted as one command and appended to a short in-order queue. An overflow flag records a push that arrives while the queue is full.

The engine takes the oldest command and works through it in steps. Each step reads a run of 32-bit words from the source into a local chunk buffer. In loopback mode it then writes that same run back out to the destination. Without loopback the source data is only consumed. When a command has nothing left to move, it leaves the queue and two completion flags are raised. The engine then moves on to the next queued command, if there is one. All memory traffic uses one valid/ready request port. Read data is returned in the same cycle the read is accepted.

Top module: `qdma_engine`

## Requirements
- R1: A write with `reg_sel`=3 captures the source address (sel 0), destination address (sel 1), source length (sel 2) and the written destination length as one command and appends it to the queue. `status` bit 30 means the queue is empty and is 1 after reset. `status` bit 31 means the queue holds DEPTH commands. All other status bits read 0.
- R2: Captured addresses have their two low bits cleared, so every memory request address is a multiple of 4.
- R3: Lengths are word counts. Only bits 26:0 of a written length are kept, and the byte count is that value times 4.
- R4: A step moves at most CHUNK_WORDS words and never more than the remaining source length. Source reads use consecutive addresses that increase by 4.
- R5: In loopback mode the step is also limited by the remaining destination length. After the step's reads, the same words are written in order to consecutive destination addresses. Without loopback no write is issued.
- R6: A command retires when its next step would move zero bytes. This is when the source is exhausted, or in loopback when either length is exhausted. A zero-length command retires without memory traffic. Retiring sets `flags` bit 13 (done) and bit 12 (partial done).
- R7: Commands are processed strictly in push order until the queue is empty. A request held without `mem_ready` keeps its address and direction.
- R8: A push while the queue is full is dropped and sets `flags` bit 14 (overflow).
- R9: A write with `reg_sel`=5 clears each `flags` bit where the written data has a 1.
- R10: Loopback is bit 4 of the control register (`reg_sel`=4). Other bits of that register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 src addr, 1 dst addr, 2 src len, 3 dst len/push, 4 control, 5 flag clear) |
| reg_wdata | input | 32 | Register write data |
| status | output | 32 | Queue full (bit 31) and empty (bit 30) |
| flags | output | 32 | Overflow (14), done (13), partial done (12) |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned request address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid when a read is accepted |

## Verification
The bench builds the engine with DEPTH=2 and CHUNK_WORDS=4. With these values a six-word loopback transfer splits into steps of four and two words, so the read/write interleaving shows the step cap directly. A destination-limited loopback then shows the shorter bound. The two-entry queue fills after two pushes while `mem_ready` is held low. A third push therefore reaches the overflow path, and releasing the stall checks that the two accepted commands complete in push order.

// File: rtl/qdma_engine.sv
module qdma_engine #(
  parameter int DEPTH       = 4,
  parameter int CHUNK_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] status,
  output logic [31:0] flags,
  output logic        mem_valid,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = (CHUNK_WORDS > 1) ? $clog2(CHUNK_WORDS) : 1;
  localparam int IW = $clog2(CHUNK_WORDS + 1);
  localparam logic [28:0] CAP = 29'(CHUNK_WORDS * 4);

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_READ, S_WRITE} st_t;

  logic [31:0] r_src, r_dst;
  logic [26:0] r_slen;
  logic        lb;

  logic [31:0] q_src [DEPTH];
  logic [31:0] q_dst [DEPTH];
  logic [28:0] q_sl  [DEPTH];
  logic [28:0] q_dl  [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;

  st_t         st;
  logic [31:0] cur_src, cur_dst;
  logic [28:0] src_rem, dst_rem;
  logic        chunk_lb;
  logic [IW-1:0] idx, nw;
  logic [31:0] cbuf [CHUNK_WORDS];
  logic        f_ovf, f_done, f_pdone;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire full    = (cnt == CW'(DEPTH));
  wire empty   = (cnt == '0);
  wire push    = reg_wr && reg_sel == 3'd3;
  wire push_ok = push && !full;

  wire [28:0] s1   = (src_rem < CAP) ? src_rem : CAP;
  wire [28:0] step = (lb && dst_rem < s1) ? dst_rem : s1;
  wire retire = (st == S_STEP) && step == '0;
  wire acc    = mem_valid && mem_ready;
  wire last   = (idx == nw - 1'b1);

  assign status    = {full, empty, 30'b0};
  assign flags     = {17'b0, f_ovf, f_done, f_pdone, 12'b0};
  assign mem_valid = (st == S_READ) || (st == S_WRITE);
  assign mem_we    = (st == S_WRITE);
  assign mem_addr  = (st == S_WRITE) ? cur_dst : cur_src;
  assign mem_wdata = cbuf[idx[BW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_src <= '0; r_dst <= '0; r_slen <= '0; lb <= 1'b0;
    end else if (reg_wr) begin
      case (reg_sel)
        3'd0: r_src  <= reg_wdata;
        3'd1: r_dst  <= reg_wdata;
        3'd2: r_slen <= reg_wdata[26:0];
        3'd4: lb     <= reg_wdata[4];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      q_src[tail] <= {r_src[31:2], 2'b00};
      q_dst[tail] <= {r_dst[31:2], 2'b00};
      q_sl[tail]  <= {r_slen, 2'b00};
      q_dl[tail]  <= {reg_wdata[26:0], 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0; tail <= '0; cnt <= '0;
    end else begin
      if (push_ok) tail <= nxt(tail);
      if (retire)  head <= nxt(head);
      cnt <= cnt + CW'(push_ok) - CW'(retire);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_ovf <= 1'b0; f_done <= 1'b0; f_pdone <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == 3'd5) begin
        f_ovf   <= f_ovf   & ~reg_wdata[14];
        f_done  <= f_done  & ~reg_wdata[13];
        f_pdone <= f_pdone & ~reg_wdata[12];
      end
      if (push && full) f_ovf <= 1'b1;
      if (retire) begin
        f_done  <= 1'b1;
        f_pdone <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; nw <= '0; chunk_lb <= 1'b0;
      cur_src <= '0; cur_dst <= '0; src_rem <= '0; dst_rem <= '0;
    end else begin
      case (st)
        S_IDLE: if (!empty) begin
          cur_src <= q_src[head];
          cur_dst <= q_dst[head];
          src_rem <= q_sl[head];
          dst_rem <= q_dl[head];
          st      <= S_STEP;
        end
        S_STEP: begin
          if (step == '0) st <= S_IDLE;
          else begin
            nw       <= IW'(step >> 2);
            idx      <= '0;
            chunk_lb <= lb;
            st       <= S_READ;
          end
        end
        S_READ: if (acc) begin
          cbuf[idx[BW-1:0]] <= mem_rdata;
          cur_src <= cur_src + 32'd4;
          src_rem <= src_rem - 29'd4;
          idx     <= last ? '0 : idx + 1'b1;
          if (last) st <= chunk_lb ? S_WRITE : S_STEP;
        end
        S_WRITE: if (acc) begin
          cur_dst <= cur_dst + 32'd4;
          dst_rem <= dst_rem - 29'd4;
          idx     <= last ? '0 : idx + 1'b1;
          if (last) st <= S_STEP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module qdma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_sel,
  input logic [31:0] status,
  input logic [31:0] flags,
  input logic        mem_valid,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_ready
);
  // R1
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[31] && status[30]));
  // R2
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));
  // R6
  done_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[12]) |-> flags[13]);
  // R8
  push_full_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_sel == 3'd3 && status[31] |=> flags[14]);
endmodule

bind qdma_engine qdma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .status(status), .flags(flags), .mem_valid(mem_valid), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/qdma_engine_test.sv
module qdma_engine_test;
  localparam int DEPTH = 2;
  localparam int CW    = 4;

  logic clk = 0, rst_n = 0, reg_wr = 0, mem_ready = 0, stall = 0;
  logic [2:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] status, flags, mem_addr, mem_wdata, mem_rdata;
  logic        mem_valid, mem_we;
  int total = 0, bad = 0, cyc = 0;
  bit lb_m = 0;
  logic [64:0] expq[$];

  always #5 clk = ~clk;

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction
  assign mem_rdata = memfn(mem_addr);

  qdma_engine #(.DEPTH(DEPTH), .CHUNK_WORDS(CW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .status(status), .flags(flags),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 mem_ready <= !stall && (cyc % 3 != 1);
  end

  always @(posedge clk) if (cyc > 100000) begin
    bad++; total++;
    $display("FAIL watchdog: act=%0d exp=<100000 cycles", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each accepted request against the scoreboard
  always @(negedge clk) if (rst_n && mem_valid && mem_ready) begin
    logic [64:0] got, e;
    got = {mem_we, mem_addr, mem_we ? mem_wdata : 32'h0};
    if (expq.size() == 0) check(0, "R5 unexpected request", got, 65'h0);
    else begin
      e = expq.pop_front();
      check(got == e, "R4/R5/R7 request order", got, e);
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  // driver: post a command and queue the expected requests
  task automatic push_cmd(input logic [31:0] sa, input logic [31:0] da,
                          input logic [31:0] sl, input logic [31:0] dl, input bit expect_kept);
    logic [31:0] s, d, sb, db, st;
    wr(0, sa); wr(1, da); wr(2, sl); wr(3, dl);
    if (!expect_kept) return;
    s = {sa[31:2], 2'b00}; d = {da[31:2], 2'b00};
    sb = {3'b0, sl[26:0], 2'b00}; db = {3'b0, dl[26:0], 2'b00};
    forever begin
      st = (sb < CW*4) ? sb : CW*4;
      if (lb_m && db < st) st = db;
      if (st == 0) break;
      for (int i = 0; i < st/4; i++) expq.push_back({1'b0, s + 32'(i*4), 32'h0});
      if (lb_m)
        for (int i = 0; i < st/4; i++) expq.push_back({1'b1, d + 32'(i*4), memfn(s + 32'(i*4))});
      s += st; sb -= st;
      if (lb_m) begin d += st; db -= st; end
    end
  endtask

  task automatic finish_cmds(input string tag);
    while (!status[30] || expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(flags[13:12] == 2'b11, {tag, " R6 done flags"}, 65'(flags), 65'h3000);
    wr(5, 32'h0000_3000);
    @(negedge clk);
    check(flags == 0, "R9 flags cleared", 65'(flags), 65'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(status == 32'h4000_0000, "R1 reset status", 65'(status), 65'h4000_0000);
    check(flags == 0, "R6 reset flags", 65'(flags), 65'h0);

    // R2 R3 R4: unaligned addresses, masked length, no loopback
    push_cmd(32'h103, 32'h202, 32'h0800_0006, 32'h0, 1);
    finish_cmds("A");

    // R5 R4: loopback, 6 words split into 4 + 2
    wr(4, 32'h10); lb_m = 1;
    push_cmd(32'h40, 32'h300, 6, 6, 1);
    finish_cmds("B");

    // R5: destination-limited loopback step
    push_cmd(32'h80, 32'h400, 6, 3, 1);
    finish_cmds("C");

    // R10: other control bits ignored, loopback off
    wr(4, 32'hFFFF_FFEF); lb_m = 0;
    push_cmd(32'h500, 32'h600, 2, 5, 1);
    finish_cmds("D");

    // R6: zero-length command retires without traffic
    push_cmd(32'h700, 32'h700, 0, 0, 1);
    finish_cmds("E");

    // R8 R7: fill queue under stall, overflow a third push
    stall = 1;
    wr(4, 32'h10); lb_m = 1;
    push_cmd(32'h10, 32'h800, 3, 3, 1);
    push_cmd(32'h20, 32'h900, 5, 5, 1);
    @(negedge clk);
    check(status[31] == 1'b1, "R1 queue full", 65'(status), 65'h8000_0000);
    check(flags[14] == 1'b0, "R8 no overflow yet", 65'(flags), 65'h0);
    push_cmd(32'h30, 32'hA00, 2, 2, 0);
    @(negedge clk);
    check(flags[14] == 1'b1, "R8 overflow flag", 65'(flags), 65'h4000);
    wr(5, 32'h0000_4000);
    @(negedge clk);
    check(flags[14] == 1'b0, "R9 overflow cleared", 65'(flags), 65'h0);
    stall = 0;
    finish_cmds("F");
    check(expq.size() == 0, "R7 all expected requests seen", 65'(expq.size()), 65'h0);
    check(status == 32'h4000_0000, "R1 empty after drain", 65'(status), 65'h4000_0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule